// File: doc/BRIEF.md
# Three-Thread Exclusive Lock Unit

This block keeps a small bank of exclusive locks that three instruction-issuing threads share. Each thread can present one sync instruction per cycle. The instruction is a 32-bit word: the top byte selects acquire or release, and the low bits name a lock.

The block records which thread owns each lock. An acquire is held until the lock is free or is already owned by the requester. A release clears ownership, but only when the owner issues it. When several threads compete for one lock, the block picks one per cycle by rotation, so each thread gets its turn.

A thread learns the outcome through two combinational outputs. A done pulse means the instruction completed this cycle and the thread may advance. A stall level means it must present the same instruction again next cycle. A per-thread stall mask and a pending flag can hold a thread's sync instructions at the gate.

Top module: `mutex_unit`

## Requirements
- R1: After reset every lock is unowned, so the first acquire of any lock completes in the cycle it is presented.
- R2: Bits [31:24] carry the opcode: 0xA0 means acquire and 0xA1 means release. The lock is selected by bits [2:0], where code 0 maps to lock 0, code 2 to lock 1, code 3 to lock 2 and code 4 to lock 3. Bits [23:3] are ignored.
- R3: An acquire or release whose index code is 1, 5, 6 or 7 raises stall and never raises done, for as long as it is presented.
- R4: An acquire of a free lock raises done in the same cycle, and from the next cycle the requester owns the lock.
- R5: An acquire of a lock owned by another thread raises stall and no done until the lock becomes free.
- R6: An acquire by the thread that already owns the lock completes at once, and ownership does not change.
- R7: A release by the owner completes and frees the lock. A release by any other thread completes without changing the owner.
- R8: When thread t releases a lock while both other threads wait to acquire it, thread (t+1) mod 3 acquires it in the next cycle.
- R9: Operations by different threads on different locks all complete in the same cycle.
- R10: At most one operation completes per lock per cycle. Among same-cycle requesters of a lock, the choice rotates and starts after the most recent thread to take that lock.
- R11: A thread whose stall mask bit 1 (value 0x02) is set while its pending flag is high has its sync instruction held with stall and no done. Other mask bits do not hold it.
- R12: A valid word with an opcode other than 0xA0 or 0xA1 raises neither done nor stall and leaves every lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 3 | Per-thread instruction present |
| instrWord | input | 3x32 | Per-thread instruction word |
| stallMask | input | 3x8 | Per-thread latched stall mask; bit 1 gates sync instructions |
| waitPending | input | 3 | Per-thread flag: the stall condition is not yet met |
| done | output | 3 | Per-thread completion this cycle |
| stall | output | 3 | Per-thread hold: present the instruction again |

## Verification
The following properties are checked on every cycle:
- done and stall are never high together.
- A bad index always stalls.
- A gated thread never completes.
- An unknown opcode stays silent.
- Two threads never complete on the same lock in one cycle.
- A completed acquire leaves the requester as owner.
- Ownership changes only in a cycle that has a completion.

Some behaviours need ordered sequences, so only the bench scenarios can show them:
- The rotation that hands a released lock to the next thread.
- Re-entrant acquire.
- A release by a non-owner having no effect.
- Waiting threads being served in turn.

A random phase compares every cycle with a reference model.

// File: rtl/mutex_pkg.sv
package mutex_pkg;
  localparam int NUM_THREADS   = 3;
  localparam int NUM_LOCKS     = 4;
  localparam int INSTR_W       = 32;
  localparam int OPC_W         = 8;
  localparam int MASK_W        = 8;
  localparam int SYNC_MASK_BIT = 1;
  localparam int IDX_BITS      = 3;
  localparam int OWN_W         = $clog2(NUM_THREADS + 1);
  localparam int TID_W         = $clog2(NUM_THREADS);

  localparam logic [OPC_W-1:0] OPC_ACQ = 8'hA0;
  localparam logic [OPC_W-1:0] OPC_REL = 8'hA1;

  typedef logic [OWN_W-1:0] owner_t;  // 0 = free, t+1 = thread t
  typedef logic [TID_W-1:0] tid_t;

  localparam owner_t OWNER_FREE = '0;

  typedef struct packed {
    logic                 ok;
    logic [TID_W-1:0]     lock;
  } lock_sel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic   [NUM_LOCKS-1:0]            wrOwner;
    owner_t [NUM_LOCKS-1:0]            newOwner;
    logic   [NUM_LOCKS-1:0]            wrPtr;
    tid_t   [NUM_LOCKS-1:0]            newPtr;
  } lock_strobe_t;

  function automatic lock_sel_t decodeIndex(input logic [IDX_BITS-1:0] code);
    lock_sel_t r;
    r.ok   = 1'b1;
    r.lock = '0;
    case (code)
      3'd0: r.lock = 2'd0;
      3'd2: r.lock = 2'd1;
      3'd3: r.lock = 2'd2;
      3'd4: r.lock = 2'd3;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  function automatic tid_t nextTid(input int t);
    return (t == NUM_THREADS - 1) ? tid_t'(0) : tid_t'(t + 1);
  endfunction
endpackage

// File: rtl/mutex_ctrl.sv
module mutex_ctrl
  import mutex_pkg::*;
(
  input  logic [NUM_THREADS-1:0]              instrValid,
  input  logic [NUM_THREADS-1:0][INSTR_W-1:0] instrWord,
  input  logic [NUM_THREADS-1:0][MASK_W-1:0]  stallMask,
  input  logic [NUM_THREADS-1:0]              waitPending,
  input  owner_t [NUM_LOCKS-1:0]              ownerQ,
  input  tid_t   [NUM_LOCKS-1:0]              ptrQ,
  output logic [NUM_THREADS-1:0]              done,
  output logic [NUM_THREADS-1:0]              stall,
  output lock_strobe_t                        strobe
);
  logic [NUM_THREADS-1:0] isAcq, isRel, isSync, eligible;
  tid_t [NUM_THREADS-1:0] lockId;
  logic [NUM_LOCKS-1:0][NUM_THREADS-1:0] lockGrant;

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      lock_sel_t sel;
      logic gateOpen;
      owner_t cur;
      sel       = decodeIndex(instrWord[t][IDX_BITS-1:0]);
      isAcq[t]  = instrValid[t] && (instrWord[t][INSTR_W-1 -: OPC_W] == OPC_ACQ);
      isRel[t]  = instrValid[t] && (instrWord[t][INSTR_W-1 -: OPC_W] == OPC_REL);
      isSync[t] = isAcq[t] || isRel[t];
      lockId[t] = sel.lock;
      gateOpen  = !(stallMask[t][SYNC_MASK_BIT] && waitPending[t]);
      cur       = ownerQ[sel.lock];
      eligible[t] = isSync[t] && sel.ok && gateOpen &&
                    (isRel[t] || cur == OWNER_FREE || cur == owner_t'(t + 1));
    end
  end

  for (genvar gl = 0; gl < NUM_LOCKS; gl++) begin : g_lock
    always_comb begin
      logic found;
      found = 1'b0;
      lockGrant[gl]        = '0;
      strobe.wrOwner[gl]   = 1'b0;
      strobe.newOwner[gl]  = OWNER_FREE;
      strobe.wrPtr[gl]     = 1'b0;
      strobe.newPtr[gl]    = '0;
      for (int k = 0; k < NUM_THREADS; k++) begin
        int tt;
        tt = int'(ptrQ[gl]) + k;
        if (tt >= NUM_THREADS) tt = tt - NUM_THREADS;
        if (!found && eligible[tt] && lockId[tt] == tid_t'(gl)) begin
          found = 1'b1;
          lockGrant[gl][tt] = 1'b1;
          if (isAcq[tt]) begin
            strobe.wrOwner[gl]  = 1'b1;
            strobe.newOwner[gl] = owner_t'(tt + 1);
            strobe.wrPtr[gl]    = 1'b1;
            strobe.newPtr[gl]   = nextTid(tt);
          end else if (ownerQ[gl] == owner_t'(tt + 1)) begin
            strobe.wrOwner[gl]  = 1'b1;
            strobe.newOwner[gl] = OWNER_FREE;
            strobe.wrPtr[gl]    = 1'b1;
            strobe.newPtr[gl]   = nextTid(tt);
          end
        end
      end
    end
  end

  always_comb begin
    done = '0;
    for (int l = 0; l < NUM_LOCKS; l++) done = done | lockGrant[l];
    stall = isSync & ~done;
  end
endmodule

// File: rtl/mutex_dp.sv
module mutex_dp
  import mutex_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  lock_strobe_t           strobe,
  output owner_t [NUM_LOCKS-1:0] ownerQ,
  output tid_t   [NUM_LOCKS-1:0] ptrQ
);
  for (genvar gl = 0; gl < NUM_LOCKS; gl++) begin : g_lock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ownerQ[gl] <= OWNER_FREE;
        ptrQ[gl]   <= '0;
      end else begin
        if (strobe.wrOwner[gl]) ownerQ[gl] <= strobe.newOwner[gl];
        if (strobe.wrPtr[gl])   ptrQ[gl]   <= strobe.newPtr[gl];
      end
    end
  end
endmodule

// File: rtl/mutex_unit.sv
module mutex_unit
  import mutex_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_THREADS-1:0]              instrValid,
  input  logic [NUM_THREADS-1:0][INSTR_W-1:0] instrWord,
  input  logic [NUM_THREADS-1:0][MASK_W-1:0]  stallMask,
  input  logic [NUM_THREADS-1:0]              waitPending,
  output logic [NUM_THREADS-1:0]              done,
  output logic [NUM_THREADS-1:0]              stall
);
  owner_t [NUM_LOCKS-1:0] ownerQ;
  tid_t   [NUM_LOCKS-1:0] ptrQ;
  lock_strobe_t           strobe;

  mutex_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .stallMask  (stallMask),
    .waitPending(waitPending),
    .ownerQ     (ownerQ),
    .ptrQ       (ptrQ),
    .done       (done),
    .stall      (stall),
    .strobe     (strobe)
  );

  mutex_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .ownerQ(ownerQ),
    .ptrQ  (ptrQ)
  );
endmodule

// File: rtl/mutex_unit_chk.sv
module mutex_unit_chk
  import mutex_pkg::*;
(
  input logic                                clk,
  input logic                                rstN,
  input logic [NUM_THREADS-1:0]              instrValid,
  input logic [NUM_THREADS-1:0][INSTR_W-1:0] instrWord,
  input logic [NUM_THREADS-1:0][MASK_W-1:0]  stallMask,
  input logic [NUM_THREADS-1:0]              waitPending,
  input logic [NUM_THREADS-1:0]              done,
  input logic [NUM_THREADS-1:0]              stall,
  input owner_t [NUM_LOCKS-1:0]              ownerQ
);
  logic [NUM_THREADS-1:0] acqOp, relOp, badIdx;
  tid_t [NUM_THREADS-1:0] lockOf;

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      lock_sel_t s;
      s = decodeIndex(instrWord[t][IDX_BITS-1:0]);
      acqOp[t]  = instrValid[t] && instrWord[t][INSTR_W-1 -: OPC_W] == OPC_ACQ;
      relOp[t]  = instrValid[t] && instrWord[t][INSTR_W-1 -: OPC_W] == OPC_REL;
      badIdx[t] = !s.ok;
      lockOf[t] = s.lock;
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    AST_DONE_XOR_STALL: assert property (@(posedge clk) disable iff (!rstN)
      !(done[t] && stall[t])); // R5
    AST_BAD_INDEX_STALL: assert property (@(posedge clk) disable iff (!rstN)
      ((acqOp[t] || relOp[t]) && badIdx[t]) |-> (stall[t] && !done[t])); // R3
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (stallMask[t][SYNC_MASK_BIT] && waitPending[t]) |-> !done[t]); // R11
    AST_UNKNOWN_OP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (!acqOp[t] && !relOp[t]) |-> (!done[t] && !stall[t])); // R12
    AST_ACQ_OWNS: assert property (@(posedge clk) disable iff (!rstN)
      (done[t] && acqOp[t]) |=> ownerQ[$past(lockOf[t])] == owner_t'(t + 1)); // R4
    for (genvar u = t + 1; u < NUM_THREADS; u++) begin : g_pair
      AST_ONE_PER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
        !(done[t] && done[u] && lockOf[t] == lockOf[u])); // R10
    end
  end

  AST_OWNER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (done == '0) |=> $stable(ownerQ)); // R7
endmodule

bind mutex_unit mutex_unit_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .stallMask  (stallMask),
  .waitPending(waitPending),
  .done       (done),
  .stall      (stall),
  .ownerQ     (ownerQ)
);

// File: tb/tb_mutex_unit.sv
`timescale 1ns/1ps
module tb_mutex_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0]       tbValid = '0;
  logic [2:0][31:0] tbWord  = '0;
  logic [2:0][7:0]  tbMask  = '0;
  logic [2:0]       tbPend  = '0;
  logic [2:0]       done, stall;

  int total = 0;
  int bad   = 0;

  int mOwner [4];   // 0 free, t+1 thread t
  int mPtr   [4];
  int nOwner [4];
  int nPtr   [4];

  always #2 clk = ~clk;   // 250 MHz

  mutex_unit dut (
    .clk(clk), .rstN(rstN), .instrValid(tbValid), .instrWord(tbWord),
    .stallMask(tbMask), .waitPending(tbPend), .done(done), .stall(stall)
  );

  function automatic logic [31:0] mk(input logic [7:0] op, input int idx);
    return {op, 24'(idx)};
  endfunction

  function automatic int lockIdx(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd2: return 1;
      3'd3: return 2;
      3'd4: return 3;
      default: return -1;
    endcase
  endfunction

  // reference model per the requirements
  task automatic modelEval(output logic [2:0] eDone, output logic [2:0] eStall);
    logic [2:0] acq, rel, can;
    int lk [3];
    eDone = '0;
    for (int l = 0; l < 4; l++) begin nOwner[l] = mOwner[l]; nPtr[l] = mPtr[l]; end
    for (int t = 0; t < 3; t++) begin
      acq[t] = tbValid[t] && tbWord[t][31:24] == 8'hA0;
      rel[t] = tbValid[t] && tbWord[t][31:24] == 8'hA1;
      lk[t]  = lockIdx(tbWord[t][2:0]);
      can[t] = (acq[t] || rel[t]) && lk[t] >= 0 && !(tbMask[t][1] && tbPend[t]);
      if (can[t] && acq[t] && !(mOwner[lk[t]] == 0 || mOwner[lk[t]] == t + 1)) can[t] = 1'b0;
    end
    for (int l = 0; l < 4; l++) begin
      for (int k = 0; k < 3; k++) begin
        int w;
        w = (mPtr[l] + k) % 3;
        if (can[w] && lk[w] == l && !(|(eDone & ((acq | rel) & {lk[2] == l, lk[1] == l, lk[0] == l})))) begin
          eDone[w] = 1'b1;
          if (acq[w]) begin nOwner[l] = w + 1; nPtr[l] = (w + 1) % 3; end
          else if (mOwner[l] == w + 1) begin nOwner[l] = 0; nPtr[l] = (w + 1) % 3; end
        end
      end
    end
    eStall = (acq | rel) & ~eDone;
  endtask

  task automatic commit();
    for (int l = 0; l < 4; l++) begin mOwner[l] = nOwner[l]; mPtr[l] = nPtr[l]; end
  endtask

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one cycle: inputs already set after a negedge; check literal and model
  task automatic cyc(input logic [2:0] expD, input logic [2:0] expS, input string req);
    logic [2:0] mD, mS;
    #1;
    modelEval(mD, mS);
    chk(req, done, expD, "done");
    chk(req, stall, expS, "stall");
    chk(req, done, mD, "done-vs-model");
    commit();
    @(negedge clk);
  endtask

  task automatic setT(input int t, input logic v, input logic [31:0] w);
    tbValid[t] = v;
    tbWord[t]  = w;
  endtask

  task automatic idleAll();
    tbValid = '0; tbWord = '0; tbMask = '0; tbPend = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] lastDone, mD, mS;
    logic [2:0] act;
    void'($urandom(32'hC0FFEE));
    for (int l = 0; l < 4; l++) begin mOwner[l] = 0; mPtr[l] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", done, 3'b000, "reset-done");
    chk("R1", stall, 3'b000, "reset-stall");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R4: fresh lock taken at once
    setT(0, 1, mk(8'hA0, 0));
    cyc(3'b001, 3'b000, "R1_R4");
    // R5: others wait
    setT(0, 0, 0); setT(1, 1, mk(8'hA0, 0)); setT(2, 1, mk(8'hA0, 0));
    cyc(3'b000, 3'b110, "R5");
    // R6: re-entrant acquire
    setT(0, 1, mk(8'hA0, 0));
    cyc(3'b001, 3'b110, "R6");
    // R7 owner release, R8 hand-off to thread 1
    setT(0, 1, mk(8'hA1, 0));
    cyc(3'b001, 3'b110, "R7");
    setT(0, 0, 0);
    cyc(3'b010, 3'b100, "R8");
    // R7: non-owner release has no effect; thread 2 still blocked
    setT(1, 0, 0); setT(0, 1, mk(8'hA1, 0));
    cyc(3'b001, 3'b100, "R7");
    setT(0, 0, 0);
    cyc(3'b000, 3'b100, "R7");
    setT(1, 1, mk(8'hA1, 0));
    cyc(3'b010, 3'b100, "R7");
    setT(1, 0, 0);
    cyc(3'b100, 3'b000, "R5");
    setT(2, 1, mk(8'hA1, 0));
    cyc(3'b100, 3'b000, "R7");
    idleAll();

    // R9 and R2: three locks at once, upper index bits set
    setT(0, 1, 32'hA0FFFFF2); setT(1, 1, 32'hA0ABCDE3); setT(2, 1, 32'hA0123454);
    cyc(3'b111, 3'b000, "R9_R2");
    setT(0, 1, 32'hA1FFFFF2); setT(1, 1, 32'hA1ABCDE3); setT(2, 1, 32'hA1123454);
    cyc(3'b111, 3'b000, "R9_R2");
    idleAll();

    // R3: bad indices hang
    setT(0, 1, mk(8'hA0, 1)); setT(1, 1, mk(8'hA1, 5)); setT(2, 1, mk(8'hA0, 7));
    cyc(3'b000, 3'b111, "R3");
    cyc(3'b000, 3'b111, "R3");
    idleAll();

    // R11: sync bit gates, other bits do not
    tbMask[1] = 8'h02; tbPend[1] = 1'b1; setT(1, 1, mk(8'hA0, 2));
    cyc(3'b000, 3'b010, "R11");
    tbMask[1] = 8'hFD;
    cyc(3'b010, 3'b000, "R11");
    tbMask[1] = 8'h00; setT(1, 1, mk(8'hA1, 2));
    cyc(3'b010, 3'b000, "R11");
    idleAll();

    // R12: unknown opcode is silent; lock 0 still free afterwards
    setT(2, 1, 32'h55000000); setT(1, 1, 32'hA2000000);
    cyc(3'b000, 3'b000, "R12");
    setT(1, 0, 0); setT(2, 0, 0); setT(0, 1, mk(8'hA0, 0));
    cyc(3'b001, 3'b000, "R12");
    setT(0, 1, mk(8'hA1, 0));
    cyc(3'b001, 3'b000, "R12");
    idleAll();

    // R10: same-lock race; lock code 3 last taken by thread 1 -> thread 2 first
    for (int t = 0; t < 3; t++) setT(t, 1, mk(8'hA0, 3));
    cyc(3'b100, 3'b011, "R10");
    setT(2, 0, 0);
    cyc(3'b000, 3'b011, "R10");
    setT(2, 1, mk(8'hA1, 3));
    cyc(3'b100, 3'b011, "R8");
    setT(2, 0, 0);
    cyc(3'b001, 3'b010, "R8");
    setT(0, 1, mk(8'hA1, 3));
    cyc(3'b001, 3'b010, "R10");
    setT(0, 0, 0);
    cyc(3'b010, 3'b000, "R10");
    setT(1, 1, mk(8'hA1, 3));
    cyc(3'b010, 3'b000, "R10");
    idleAll();

    // random phase against the model
    lastDone = '1;
    for (int n = 0; n < 4000; n++) begin
      for (int t = 0; t < 3; t++) begin
        int r;
        r = $urandom_range(0, 99);
        if (lastDone[t] || !tbValid[t] || $urandom_range(0, 15) == 0) begin
          if (r < 70) begin
            int codes [4];
            codes = '{0, 2, 3, 4};
            tbValid[t] = 1'b1;
            tbWord[t] = {($urandom_range(0, 1) == 0) ? 8'hA0 : 8'hA1,
                         21'($urandom()), 3'(codes[$urandom_range(0, 3)])};
          end else if (r < 75) begin
            tbValid[t] = 1'b1;
            tbWord[t] = {8'h3C, 24'($urandom())};
          end else begin
            tbValid[t] = 1'b0;
            tbWord[t] = '0;
          end
        end
        tbMask[t] = ($urandom_range(0, 3) == 0) ? 8'h02 : 8'($urandom_range(0, 255)) & 8'hFD;
        tbPend[t] = 1'($urandom_range(0, 1));
      end
      #1;
      modelEval(mD, mS);
      act = done;
      chk("R10", act, mD, "rand-done");
      chk("R5", stall, mS, "rand-stall");
      lastDone = act;
      commit();
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule